// File: doc/BRIEF.md
# Ping-Pong DMA Word Address Sequencer

This block produces the memory word addresses for an internal DMA engine that moves 32-bit words between a data FIFO and system memory. A simple request/acknowledge handshake stands in for the memory bus. Each acknowledged word advances the address by four bytes. The transfer stops when a total word count, given at start, runs out.

In single-buffer mode the sequencer walks upward from base 0 only. In double-buffer mode it works through two memory buffers in turn. Each buffer holds a programmable number of 8-word units. When a buffer is finished, hardware flips an active-buffer indicator, emits a one-cycle completion pulse and reloads the address from the other buffer's base. While a transfer runs, firmware may refill the base of whichever buffer is not in use, so buffers can be recycled without stopping. A memory-side error aborts the run and leaves a sticky error flag.

Top module: `ppbuf_addr_seq`

## Requirements
- R1: After reset, req, addr, act_buf, buf_done, xfer_err, base0 and base1 are all zero.
- R2: When idle, a start pulse is accepted if the stored configuration is enabled, total_words is nonzero, and double mode does not have a size of 0. In the next cycle, req is 1 and addr equals the base of the starting buffer. The starting buffer is cfg_act in double mode and buffer 0 in single mode.
- R3: In every cycle with req=1, ack=1 and err_in=0, one word completes. If no buffer switch happens on that word, addr rises by 4. When the last of total_words completes, req is 0 from the next cycle.
- R4: In double mode, a buffer holds cfg_size×8 words. After its last word is acknowledged, buf_done is 1 for exactly one cycle, act_buf inverts, and addr loads from the base of the newly active buffer. This also applies when that word is the final word of the transfer.
- R5: In single mode, act_buf stays 0 and buf_done never rises.
- R6: Base writes always store bits [1:0] as 0. While idle, either base (base_sel 0 or 1) accepts writes. While running, a write to the base selected by act_buf is ignored, and a write to the other base takes effect.
- R7: Configuration writes (cfg_we) are applied only while idle; while req is 1 they are ignored and later transfers use the earlier settings.
- R8: err_in while running ends the transfer (req 0 in the next cycle) and sets xfer_err. The same cycle's ack is not counted. xfer_err stays 1 until the next accepted start clears it.
- R9: ack while req is 0 has no effect: addr, act_buf and buf_done do not change.
- R10: Start is refused, and req stays 0, when the block is disabled, when total_words is 0, or when double mode is selected with size 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe (honoured only while idle) |
| cfg_en | input | 1 | Sequencer enable |
| cfg_dbl | input | 1 | 1 = double-buffer mode, 0 = single-buffer mode |
| cfg_size | input | 8 | Buffer size in units of 8 words |
| cfg_act | input | 1 | Starting buffer for double mode |
| base_wr | input | 1 | Base address write strobe |
| base_sel | input | 1 | Base register selected for writing (0 or 1) |
| base_wdata | input | 32 | Base address write data |
| start | input | 1 | Start a transfer |
| total_words | input | 16 | Number of words in the transfer, sampled at start |
| req | output | 1 | Word transfer request (high while running) |
| ack | input | 1 | Word acknowledged by memory side |
| err_in | input | 1 | Memory-side error |
| addr | output | 32 | Byte address of the current word |
| act_buf | output | 1 | Active buffer indicator |
| buf_done | output | 1 | One-cycle pulse when a buffer is complete |
| xfer_err | output | 1 | Sticky transfer error flag |
| base0 | output | 32 | Buffer 0 base readback |
| base1 | output | 32 | Buffer 1 base readback |

## Verification
The assertions assume that err_in and ack come from a single memory-side agent. They also assume ack matters only while req is high, and that configuration changes are requested through cfg_we and not by forcing state. The stimulus drives every input on the falling clock edge. It keeps cfg_size at 1 or more whenever double mode is expected to run. It raises err_in only for a single cycle during a run, and it holds ack steady across each buffer boundary, so a completed buffer is always followed by a clean switch cycle.

// File: rtl/ppseq_pkg.sv
package ppseq_pkg;

    localparam int unsigned SIZE_W     = 8;
    localparam int unsigned UNIT_SHIFT = 3;
    localparam int unsigned BCNT_W     = SIZE_W + UNIT_SHIFT;
    localparam int unsigned WORD_BYTES = 4;

    typedef struct packed {
        logic              en;
        logic              dbl;
        logic [SIZE_W-1:0] size;
        logic              act;
    } seq_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [BCNT_W-1:0] buf_words(input logic [SIZE_W-1:0] s);
        return {s, {UNIT_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/ppseq_ctrl.sv
module ppseq_ctrl
    import ppseq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  seq_cfg_t         cfg_in,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             ack,
    input  logic             err_in,
    output logic             busy,
    output logic             act,
    output logic             act_nxt,
    output logic             load,
    output logic             step,
    output logic             sw,
    output logic             buf_done,
    output logic             xfer_err
);

    seq_cfg_t          cfg_q;
    seq_state_e        st_q;
    logic [CNT_W-1:0]  rem_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              act_q;
    logic              start_ok;
    logic              start_act;
    logic              last_in_buf;

    assign busy        = (st_q == ST_RUN);
    assign start_ok    = start && !busy && cfg_q.en && (total != '0)
                         && !(cfg_q.dbl && (cfg_q.size == '0));
    assign step        = busy && ack && !err_in;
    assign last_in_buf = cfg_q.dbl && (bcnt_q == buf_words(cfg_q.size) - 1'b1);
    assign sw          = step && last_in_buf;
    assign start_act   = cfg_q.dbl & cfg_q.act;
    assign act_nxt     = start_ok ? start_act : (sw ? ~act_q : act_q);
    assign load        = start_ok || sw;
    assign act         = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            st_q     <= ST_IDLE;
            rem_q    <= '0;
            bcnt_q   <= '0;
            act_q    <= 1'b0;
            buf_done <= 1'b0;
            xfer_err <= 1'b0;
        end else begin
            if (cfg_we && !busy) begin
                cfg_q <= cfg_in;
            end
            act_q    <= act_nxt;
            buf_done <= sw;
            if (start_ok) begin
                st_q     <= ST_RUN;
                rem_q    <= total;
                bcnt_q   <= '0;
                xfer_err <= 1'b0;
            end else if (busy) begin
                if (err_in) begin
                    st_q     <= ST_IDLE;
                    xfer_err <= 1'b1;
                end else if (step) begin
                    rem_q  <= rem_q - 1'b1;
                    bcnt_q <= sw ? '0 : bcnt_q + 1'b1;
                    if (rem_q == CNT_W'(1)) begin
                        st_q <= ST_IDLE;
                    end
                end
            end
        end
    end

    // R5: no buffer pulse in single mode
    p_single_no_done_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.dbl |-> !buf_done);

    // R4: completion is a single-cycle pulse
    p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        buf_done |=> !buf_done);

    // R8: error stops the run and raises the flag
    p_err_stops_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && err_in) |=> (!busy && xfer_err));

    // R7: configuration frozen while running
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

endmodule

// File: rtl/ppseq_base.sv
module ppseq_base #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   busy,
    input  logic                   act,
    input  logic                   wr,
    input  logic                   sel,
    input  logic [ADDR_W-1:0]      wdata,
    output logic [1:0][ADDR_W-1:0] base_q
);

    localparam int unsigned NBUF = 2;

    for (genvar g = 0; g < NBUF; g++) begin : g_base
        logic wr_ok;
        assign wr_ok = wr && (sel == 1'(g)) && (!busy || (act != 1'(g)));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g] <= '0;
            end else if (wr_ok) begin
                base_q[g] <= {wdata[ADDR_W-1:2], 2'b00};
            end
        end

        // R6: the base of the buffer in use cannot be overwritten
        p_active_locked_r6: assert property (@(posedge clk) disable iff (rst)
            (busy && (act == 1'(g)) && wr && (sel == 1'(g))) |=> $stable(base_q[g]));
    end

endmodule

// File: rtl/ppseq_addr.sv
module ppseq_addr #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_base,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ppseq_pkg::WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_base;
        end else if (step) begin
            addr_q <= addr_q + STRIDE;
        end
    end

endmodule

// File: rtl/ppbuf_addr_seq.sv
module ppbuf_addr_seq
    import ppseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_en,
    input  logic              cfg_dbl,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_act,
    input  logic              base_wr,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              start,
    input  logic [CNT_W-1:0]  total_words,
    output logic              req,
    input  logic              ack,
    input  logic              err_in,
    output logic [ADDR_W-1:0] addr,
    output logic              act_buf,
    output logic              buf_done,
    output logic              xfer_err,
    output logic [ADDR_W-1:0] base0,
    output logic [ADDR_W-1:0] base1
);

    seq_cfg_t                cfg_in;
    logic                    busy;
    logic                    act_nxt;
    logic                    load;
    logic                    step;
    logic                    sw;
    logic [1:0][ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]       load_base;

    assign cfg_in    = '{en: cfg_en, dbl: cfg_dbl, size: cfg_size, act: cfg_act};
    assign load_base = base_q[act_nxt];

    ppseq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_in   (cfg_in),
        .start    (start),
        .total    (total_words),
        .ack      (ack),
        .err_in   (err_in),
        .busy     (busy),
        .act      (act_buf),
        .act_nxt  (act_nxt),
        .load     (load),
        .step     (step),
        .sw       (sw),
        .buf_done (buf_done),
        .xfer_err (xfer_err)
    );

    ppseq_base #(.ADDR_W(ADDR_W)) base_i (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .act    (act_buf),
        .wr     (base_wr),
        .sel    (base_sel),
        .wdata  (base_wdata),
        .base_q (base_q)
    );

    ppseq_addr #(.ADDR_W(ADDR_W)) addr_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .load_base (load_base),
        .addr_q    (addr)
    );

    assign req   = busy;
    assign base0 = base_q[0];
    assign base1 = base_q[1];

    // R3: a plain acknowledged word moves the address one word up
    p_addr_walk_r3: assert property (@(posedge clk) disable iff (rst)
        (req && ack && !err_in && !sw) |=> (addr == $past(addr) + ADDR_W'(WORD_BYTES)));

    // R9: acknowledge without request changes nothing
    p_idle_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (!req && ack && !start) |=> ($stable(addr) && $stable(act_buf) && !buf_done));

    // R4: active buffer only flips together with a completion pulse
    p_flip_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        (req && $past(req) && (act_buf != $past(act_buf))) |-> buf_done);

endmodule

// File: tb/ppbuf_addr_seq_tb_top.sv
module ppbuf_addr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_en, cfg_dbl, cfg_act;
    logic [7:0]  cfg_size;
    logic        base_wr, base_sel;
    logic [31:0] base_wdata;
    logic        start;
    logic [15:0] total_words;
    logic        req, ack, err_in;
    logic [31:0] addr;
    logic        act_buf, buf_done, xfer_err;
    logic [31:0] base0, base1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ppbuf_addr_seq dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_dbl(cfg_dbl),
        .cfg_size(cfg_size), .cfg_act(cfg_act), .base_wr(base_wr), .base_sel(base_sel),
        .base_wdata(base_wdata), .start(start), .total_words(total_words), .req(req),
        .ack(ack), .err_in(err_in), .addr(addr), .act_buf(act_buf), .buf_done(buf_done),
        .xfer_err(xfer_err), .base0(base0), .base1(base1)
    );

    // Vector: {dbl, size[7:0], act, total[15:0], pulses[3:0], final_act}
    localparam int NVEC = 5;
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b0, 8'd0, 1'b0, 16'd5,  4'd0, 1'b0},
        {1'b1, 8'd1, 1'b0, 16'd20, 4'd2, 1'b0},
        {1'b1, 8'd1, 1'b1, 16'd16, 4'd2, 1'b1},
        {1'b1, 8'd2, 1'b0, 16'd10, 4'd0, 1'b0},
        {1'b1, 8'd1, 1'b0, 16'd8,  4'd1, 1'b1}
    };

    task automatic chk(input logic ok, input string req_tag, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act_v, exp_v);
        end
    endtask

    task automatic set_cfg(input logic en, input logic dbl, input logic [7:0] sz,
                           input logic a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_en = en; cfg_dbl = dbl; cfg_size = sz; cfg_act = a;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wbase(input logic s, input logic [31:0] d);
        @(negedge clk);
        base_wr = 1'b1; base_sel = s; base_wdata = d;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    // Runs until req drops, with ack held high; returns pulse count and mismatches
    task automatic run_model(input logic dbl, input logic [7:0] sz, input logic a0,
                             input logic [15:0] tot, output int pulses, output int bad);
        logic [31:0] cur;
        logic        act;
        int          cnt;
        @(negedge clk);
        start = 1'b1; total_words = tot; ack = 1'b1;
        act = dbl & a0; cur = act ? base1 : base0; cnt = 0; pulses = 0; bad = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (buf_done) pulses++;
            if (!req) break;
            if (addr !== cur) bad++;
            if (act_buf !== act) bad++;
            cur = cur + 32'd4;
            cnt++;
            if (dbl && cnt == int'(sz) * 8) begin
                act = ~act; cnt = 0; cur = act ? base1 : base0;
            end
        end
        ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pulses, bad;
        rst = 1'b1; cfg_we = 0; cfg_en = 0; cfg_dbl = 0; cfg_size = 0; cfg_act = 0;
        base_wr = 0; base_sel = 0; base_wdata = 0; start = 0; total_words = 0;
        ack = 0; err_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!req && !act_buf && !buf_done && !xfer_err, "R1 flags", {28'd0, req, act_buf, buf_done, xfer_err}, 0);
        chk(addr == 0 && base0 == 0 && base1 == 0, "R1 addr/base", addr | base0 | base1, 0);

        // R6 alignment while idle
        wbase(1'b0, 32'h0000_1003);
        chk(base0 == 32'h1000, "R6 align base0", base0, 32'h1000);
        wbase(1'b1, 32'h0000_8002);
        chk(base1 == 32'h8000, "R6 align base1", base1, 32'h8000);

        // Table of transfers: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            set_cfg(1'b1, VEC[v][30], VEC[v][29:22], VEC[v][21]);
            run_model(VEC[v][30], VEC[v][29:22], VEC[v][21], VEC[v][20:5], pulses, bad);
            chk(bad == 0, "R2/R3 address sequence", bad, 0);
            chk(pulses == int'(VEC[v][4:1]), "R4/R5 buffer pulses", pulses, VEC[v][4:1]);
            chk(act_buf == VEC[v][0], "R4/R5 final active buffer", act_buf, VEC[v][0]);
        end

        // R10 refusals
        set_cfg(1'b0, 1'b0, 8'd0, 1'b0);
        @(negedge clk); start = 1; total_words = 5; @(negedge clk); start = 0;
        chk(!req, "R10 disabled", req, 0);
        set_cfg(1'b1, 1'b0, 8'd0, 1'b0);
        @(negedge clk); start = 1; total_words = 0; @(negedge clk); start = 0;
        chk(!req, "R10 zero count", req, 0);
        set_cfg(1'b1, 1'b1, 8'd0, 1'b0);
        @(negedge clk); start = 1; total_words = 5; @(negedge clk); start = 0;
        chk(!req, "R10 zero size", req, 0);

        // R9 ack while idle
        begin
            logic [31:0] a_before;
            logic        b_before;
            a_before = addr; b_before = act_buf;
            ack = 1'b1; repeat (5) @(negedge clk); ack = 1'b0;
            chk(addr == a_before && act_buf == b_before && !buf_done, "R9 idle ack", addr, a_before);
        end

        // R6 live base rewrite in double mode, R4 switch to rewritten base
        wbase(1'b0, 32'h1000);
        wbase(1'b1, 32'h8000);
        set_cfg(1'b1, 1'b1, 8'd1, 1'b0);
        @(negedge clk); start = 1; total_words = 16;
        @(negedge clk); start = 0;
        chk(req && addr == 32'h1000, "R2 start addr", addr, 32'h1000);
        base_wr = 1; base_sel = 0; base_wdata = 32'h2000;
        @(negedge clk);
        chk(base0 == 32'h1000, "R6 active base write ignored", base0, 32'h1000);
        base_sel = 1; base_wdata = 32'h9000;
        @(negedge clk);
        base_wr = 0;
        chk(base1 == 32'h9000, "R6 idle base write accepted", base1, 32'h9000);
        ack = 1;
        repeat (8) @(negedge clk);
        chk(addr == 32'h9000 && act_buf && buf_done, "R4 switch to new base", addr, 32'h9000);
        for (int i = 0; i < 50 && req; i++) @(negedge clk);
        ack = 0;
        chk(addr == 32'h1000 && !act_buf, "R4 final switch back", addr, 32'h1000);

        // R7 configuration ignored while busy
        set_cfg(1'b1, 1'b0, 8'd0, 1'b0);
        @(negedge clk); start = 1; total_words = 4; ack = 1;
        @(negedge clk); start = 0; cfg_we = 1; cfg_dbl = 1; cfg_size = 8'd1;
        @(negedge clk); cfg_we = 0; cfg_dbl = 0; cfg_size = 0;
        for (int i = 0; i < 50 && req; i++) @(negedge clk);
        pulses = 0;
        start = 1; total_words = 10;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            start = 0;
            if (buf_done) pulses++;
            if (!req) break;
        end
        ack = 0;
        chk(pulses == 0, "R7 mode write ignored (pulses)", pulses, 0);
        chk(addr == 32'h1028, "R7 mode write ignored (linear addr)", addr, 32'h1028);

        // R8 error abort and clear on next start
        @(negedge clk); start = 1; total_words = 10;
        @(negedge clk); start = 0; ack = 1;
        repeat (3) @(negedge clk);
        ack = 0; err_in = 1;
        @(negedge clk); err_in = 0;
        chk(!req && xfer_err, "R8 abort", {30'd0, req, xfer_err}, 1);
        chk(addr == 32'h100C, "R8 three words moved", addr, 32'h100C);
        start = 1;
        @(negedge clk); start = 0;
        chk(req && !xfer_err && addr == 32'h1000, "R8 cleared by start", {31'd0, xfer_err}, 0);
        err_in = 1;
        @(negedge clk); err_in = 0;
        chk(!req, "R8 second abort", req, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule